// File: doc/BRIEF.md
# Bit-Band Alias Address Translator

This block sits between a 32-bit bus master and a byte-addressable memory port. Each word in an alias window stands for one bit of one byte in a matching bit-band window. An aliased read returns that bit as 0x00000001 or 0x00000000. An aliased write becomes a locked read-modify-write that changes only that bit. Every other access goes to memory unchanged, one cycle after it is accepted.

There are two windows: one for SRAM and one for peripheral registers. Each window is set by a region base, an alias base and a region size. The alias word for byte offset `k`, bit `b` sits at `alias_base + 32*k + 4*b`. The block handles one transaction at a time. Requests use a valid/ready handshake on both sides. Read data from memory comes back on a separate valid strobe, after any number of cycles.

Top module: `bitband_xlate`

## Requirements
- R1: While reset is held, and right after it is released, `req_ready` is 1 and `mem_valid`, `rsp_valid` and `mem_lock` are 0.
- R2: An address whose bits above the alias window size match an alias base is aliased. The target byte is `region_base + alias_addr[REGION_LOG2+4:5]` and the target bit number (0..7) is `alias_addr[4:2]`. With the defaults, 0x22000000 maps onto 0x20000000, 0x42000000 maps onto 0x40000000, and each window covers 1 MB. For example, 0x22006008 is bit 2 of byte 0x20000300. Downstream accesses use the word-aligned address of the target byte.
- R3: An aliased read issues one downstream read of the aligned target word with strobe 4'b1111. It returns bit `8*lane + bit` of that word in `rsp_rdata[0]`, with bits 31:1 at zero. Here `lane` is bits 1:0 of the target byte address. It issues no write.
- R4: An aliased write reads the aligned target word, then writes it back with only the target bit replaced by `req_wdata[0]`. The write-back strobe is one-hot on the target lane (`4'b0001 << lane`). The other write data bits and the request strobe have no effect.
- R5: During an aliased write, `mem_lock` is high from the issue of the read until the write-back handshake. These are the only two downstream accesses of the transaction. They go to the same address, and the write-back is issued in the cycle after the read data arrives. Aliased reads never raise `mem_lock`.
- R6: A non-aliased request appears at the memory port with its write flag, address, data and strobes unchanged. `mem_valid` rises in the cycle after the request is accepted.
- R7: Each transaction ends with a single-cycle `rsp_valid` pulse. A non-aliased read returns the memory data. Every write returns 0.
- R8: `req_ready` is high only while no transaction is in flight. It is low in the cycle after a request is accepted.
- R9: While `mem_valid` is high and `mem_ready` is low, the downstream request (valid, write, address) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data (only bit 0 used for aliased writes) |
| req_strb | input | 4 | Byte strobes for non-aliased writes |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_rdata | output | 32 | Response data |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream accepts request |
| mem_write | output | 1 | Downstream write flag |
| mem_addr | output | 32 | Downstream byte address |
| mem_wdata | output | 32 | Downstream write data |
| mem_strb | output | 4 | Downstream byte strobes |
| mem_lock | output | 1 | Downstream port held for a read-modify-write |
| mem_rvalid | input | 1 | Downstream read data valid |
| mem_rdata | input | 32 | Downstream read data |

## Verification
The bench builds the block with its default parameters: SRAM alias 0x22000000 onto 0x20000000, peripheral alias 0x42000000 onto 0x40000000, 1 MB regions. With these values both windows are reachable, so the vectors hit every byte lane, including lane 3 bit 7, the top bit of a word. A reference memory applies the same bit updates, and every aliased write is checked to yield exactly one locked read then one single-lane write. A cyclic ready pattern and a forced stall cover memory back-pressure, both in the middle of a read-modify-write and for plain pass-through accesses.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS_REQ,
    ST_PASS_WAIT,
    ST_BIT_RD_REQ,
    ST_BIT_RD_WAIT,
    ST_BIT_WR_REQ,
    ST_RESP
  } bb_state_e;

  typedef struct packed {
    logic        write;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
  } bb_req_t;

  // bit position inside a little-endian word: lane selects the byte
  function automatic logic [4:0] bb_bitpos(input logic [1:0] lane, input logic [2:0] bitsel);
    return {lane, bitsel};
  endfunction

  // replace one bit of a word
  function automatic logic [31:0] bb_merge(input logic [31:0] word, input logic [4:0] pos,
                                           input logic val);
    logic [31:0] r;
    r      = word;
    r[pos] = val;
    return r;
  endfunction

  function automatic logic [3:0] bb_lane_strb(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int                NREG        = 2,
  parameter int                REGION_LOG2 = 20,
  parameter logic [NREG-1:0][31:0] REGION_BASES = '0,
  parameter logic [NREG-1:0][31:0] ALIAS_BASES  = '0
) (
  input  logic [31:2] addr_w,
  output logic        hit,
  output logic [31:0] word_addr,
  output logic [4:0]  bit_pos
);
  localparam int ALIAS_LOG2 = REGION_LOG2 + 5;

  logic [NREG-1:0]       hit_v;
  logic [NREG-1:0][31:0] tgt_v;
  logic [31:0]           tgt;

  for (genvar r = 0; r < NREG; r++) begin : g_win
    assign hit_v[r] = (addr_w[31:ALIAS_LOG2] == ALIAS_BASES[r][31:ALIAS_LOG2]);
    assign tgt_v[r] = REGION_BASES[r] + 32'(addr_w[ALIAS_LOG2-1:5]);
  end

  always_comb begin
    tgt = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit_v[r]) tgt = tgt | tgt_v[r];
    end
  end

  assign hit       = |hit_v;
  assign word_addr = {tgt[31:2], 2'b00};
  assign bit_pos   = bb_bitpos(tgt[1:0], addr_w[4:2]);

endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
  import bb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  input  logic        dec_hit,
  input  logic [31:0] dec_word,
  input  logic [4:0]  dec_pos,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_strb,
  output logic        mem_lock,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        ev_bit_read,
  output logic        ev_rmw_read
);
  bb_state_e   state_q, state_d;
  bb_req_t     cap_q;
  logic [31:0] cap_word_q;
  logic [4:0]  cap_pos_q;
  logic [31:0] rdata_q;
  logic [31:0] merged_q;
  logic        accept;

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign ev_bit_read = (state_q == ST_BIT_RD_WAIT) && mem_rvalid && !cap_q.write;
  assign ev_rmw_read = (state_q == ST_BIT_RD_WAIT) && mem_rvalid &&  cap_q.write;

  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = cap_word_q;
    mem_wdata = '0;
    mem_strb  = 4'hF;
    mem_lock  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) state_d = dec_hit ? ST_BIT_RD_REQ : ST_PASS_REQ;
      end
      ST_PASS_REQ: begin
        mem_valid = 1'b1;
        mem_write = cap_q.write;
        mem_addr  = cap_q.addr;
        mem_wdata = cap_q.wdata;
        mem_strb  = cap_q.strb;
        if (mem_ready) state_d = cap_q.write ? ST_RESP : ST_PASS_WAIT;
      end
      ST_PASS_WAIT: begin
        if (mem_rvalid) state_d = ST_RESP;
      end
      ST_BIT_RD_REQ: begin
        mem_valid = 1'b1;
        mem_lock  = cap_q.write;
        if (mem_ready) state_d = ST_BIT_RD_WAIT;
      end
      ST_BIT_RD_WAIT: begin
        mem_lock = cap_q.write;
        if (mem_rvalid) state_d = cap_q.write ? ST_BIT_WR_REQ : ST_RESP;
      end
      ST_BIT_WR_REQ: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_wdata = merged_q;
        mem_strb  = bb_lane_strb(cap_pos_q[4:3]);
        mem_lock  = 1'b1;
        if (mem_ready) state_d = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cap_q      <= '0;
      cap_word_q <= '0;
      cap_pos_q  <= '0;
      rdata_q    <= '0;
      merged_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cap_q      <= '{write: req_write, addr: req_addr, wdata: req_wdata, strb: req_strb};
        cap_word_q <= dec_word;
        cap_pos_q  <= dec_pos;
        rdata_q    <= '0;
      end
      if (state_q == ST_PASS_WAIT && mem_rvalid) rdata_q <= mem_rdata;
      if (ev_bit_read) rdata_q <= {31'b0, mem_rdata[cap_pos_q]};
      if (ev_rmw_read) merged_q <= bb_merge(mem_rdata, cap_pos_q, cap_q.wdata[0]);
    end
  end

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bb_pkg::*;
#(
  parameter int          REGION_LOG2  = 20,
  parameter logic [31:0] SRAM_BASE    = 32'h2000_0000,
  parameter logic [31:0] SRAM_ALIAS   = 32'h2200_0000,
  parameter logic [31:0] PERIPH_BASE  = 32'h4000_0000,
  parameter logic [31:0] PERIPH_ALIAS = 32'h4200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_strb,
  output logic        mem_lock,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int NREG = 2;
  localparam logic [NREG-1:0][31:0] REGION_BASES = {PERIPH_BASE, SRAM_BASE};
  localparam logic [NREG-1:0][31:0] ALIAS_BASES  = {PERIPH_ALIAS, SRAM_ALIAS};

  logic        dec_hit;
  logic [31:0] dec_word;
  logic [4:0]  dec_pos;
  logic        ev_bit_read;
  logic        ev_rmw_read;

  bb_decode #(
    .NREG        (NREG),
    .REGION_LOG2 (REGION_LOG2),
    .REGION_BASES(REGION_BASES),
    .ALIAS_BASES (ALIAS_BASES)
  ) u_dec (
    .addr_w   (req_addr[31:2]),
    .hit      (dec_hit),
    .word_addr(dec_word),
    .bit_pos  (dec_pos)
  );

  bb_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_strb   (req_strb),
    .dec_hit    (dec_hit),
    .dec_word   (dec_word),
    .dec_pos    (dec_pos),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_strb   (mem_strb),
    .mem_lock   (mem_lock),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .ev_bit_read(ev_bit_read),
    .ev_rmw_read(ev_rmw_read)
  );

endmodule

// File: rtl/bitband_xlate_chk.sv
module bitband_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_strb,
  input logic        mem_lock,
  input logic        ev_bit_read,
  input logic        ev_rmw_read
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!mem_valid && !rsp_valid && !mem_lock && req_ready)); // R1

  AST_BIT_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit_read |=> (rsp_valid && rsp_rdata[31:1] == '0)); // R3

  AST_WRITEBACK_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_lock) |-> $countones(mem_strb) == 1); // R4

  AST_LOCK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write && mem_lock) |=> (mem_lock && !mem_valid)); // R5

  AST_WRITEBACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_read |=> (mem_valid && mem_write && mem_lock)); // R5

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> $past(mem_valid && mem_ready && mem_write)); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R9

endmodule

bind bitband_xlate bitband_xlate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_strb   (mem_strb),
  .mem_lock   (mem_lock),
  .ev_bit_read(ev_bit_read),
  .ev_rmw_read(ev_rmw_read)
);

// File: tb/sim_bitband_xlate.sv
module sim_bitband_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write, mem_lock, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_strb;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  logic stall = 1'b0;

  always #2 clk = ~clk;

  bitband_xlate u0 (.*);

  // memory model: 256 words per region, read data one cycle after handshake
  logic [31:0] mem_m [2][256];
  int          hs_cnt;
  logic [31:0] hs_addr [2];
  logic        hs_wr [2];
  logic        hs_lock [2];
  logic [3:0]  hs_strb [2];

  assign mem_ready = !stall && (cyc % 3 != 2);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int r = 0; r < 2; r++) for (int i = 0; i < 256; i++) mem_m[r][i] <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      hs_cnt     <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        hs_cnt     <= hs_cnt + 1;
        hs_addr[1] <= hs_addr[0]; hs_addr[0] <= mem_addr;
        hs_wr[1]   <= hs_wr[0];   hs_wr[0]   <= mem_write;
        hs_lock[1] <= hs_lock[0]; hs_lock[0] <= mem_lock;
        hs_strb[1] <= hs_strb[0]; hs_strb[0] <= mem_strb;
        if (mem_write) begin
          for (int b = 0; b < 4; b++)
            if (mem_strb[b]) mem_m[mem_addr[30]][mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_m[mem_addr[30]][mem_addr[9:2]];
        end
      end
    end
  end

  // bench view of the alias mapping (R2)
  function automatic logic is_alias(input logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction
  function automatic logic [31:0] target_byte(input logic [31:0] a);
    return (a & 32'hF000_0000) + ((a & 32'h01FF_FFFF) >> 5);
  endfunction

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{1'b1, 32'h2000_0300, 32'hA5A5_A5A5, 4'hF, 32'h0},
    '{1'b0, 32'h2000_0300, 32'h0,         4'hF, 32'hA5A5_A5A5},
    '{1'b0, 32'h2200_6008, 32'h0,         4'hF, 32'h1},
    '{1'b0, 32'h2200_6004, 32'h0,         4'hF, 32'h0},
    '{1'b1, 32'h2200_6004, 32'hFFFF_FFFF, 4'hF, 32'h0},
    '{1'b1, 32'h2200_6008, 32'hFFFF_FFFE, 4'hF, 32'h0},
    '{1'b0, 32'h2000_0300, 32'h0,         4'hF, 32'hA5A5_A5A3},
    '{1'b1, 32'h2200_607C, 32'h0,         4'h0, 32'h0},
    '{1'b0, 32'h2000_0300, 32'h0,         4'hF, 32'h25A5_A5A3},
    '{1'b1, 32'h4000_0010, 32'h0000_F00F, 4'h3, 32'h0},
    '{1'b1, 32'h4200_0240, 32'h0000_0001, 4'hF, 32'h0},
    '{1'b0, 32'h4200_023C, 32'h0,         4'hF, 32'h1},
    '{1'b0, 32'h4000_0010, 32'h0,         4'hF, 32'h0001_F00F},
    '{1'b0, 32'h4200_0240, 32'h0,         4'hF, 32'h1},
    '{1'b1, 32'h2000_0300, 32'h00FF_0000, 4'h4, 32'h0},
    '{1'b0, 32'h2000_0300, 32'h0,         4'hF, 32'h25FF_A5A3},
    '{1'b0, 32'h2200_6058, 32'h0,         4'hF, 32'h1}
  };

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] exp_maddr, seen_addr, tgt;
    logic        seen_valid, seen_ready;
    int          hs0, guard;
    string       tag;
    tgt       = target_byte(v.addr);
    exp_maddr = is_alias(v.addr) ? {tgt[31:2], 2'b00} : v.addr;
    tag       = is_alias(v.addr) ? (v.wr ? "R4" : "R3") : "R6";
    @(negedge clk);
    hs0       = hs_cnt;
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata; req_strb = v.strb;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid  = 1'b0;
    seen_valid = mem_valid;
    seen_addr  = mem_addr;
    seen_ready = req_ready;
    check(seen_valid && seen_addr == exp_maddr, "R2", $sformatf("vec %0d downstream address", idx),
          seen_addr, exp_maddr);
    check(!seen_ready, "R8", $sformatf("vec %0d ready after accept", idx),
          32'(seen_ready), 32'h0);
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    check(rsp_valid && rsp_rdata == v.exp, tag, $sformatf("vec %0d response (R7)", idx),
          rsp_rdata, v.exp);
    if (is_alias(v.addr) && v.wr) begin
      // R5: exactly one locked read then one locked single-lane write, same word
      check(hs_cnt - hs0 == 2 && !hs_wr[1] && hs_wr[0] && hs_lock[1] && hs_lock[0]
            && hs_addr[1] == exp_maddr && hs_addr[0] == exp_maddr
            && hs_strb[0] == (4'b0001 << tgt[1:0]), "R5", $sformatf("vec %0d rmw sequence", idx),
            {hs_addr[0][27:0], hs_strb[0]}, {exp_maddr[27:0], 4'b0001 << tgt[1:0]});
    end else begin
      check(hs_cnt - hs0 == 1 && hs_wr[0] == v.wr && !hs_lock[0]
            && (is_alias(v.addr) ? hs_strb[0] == 4'hF : hs_strb[0] == v.strb),
            is_alias(v.addr) ? "R3" : "R6", $sformatf("vec %0d single access", idx),
            32'(hs_cnt - hs0), 32'd1);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready && !mem_valid && !rsp_valid && !mem_lock, "R1", "outputs during reset",
          {28'h0, req_ready, mem_valid, rsp_valid, mem_lock}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_valid && !rsp_valid && !mem_lock, "R1", "outputs after reset",
          {28'h0, req_ready, mem_valid, rsp_valid, mem_lock}, 32'h8);

    for (int i = 0; i < 17; i++) run_vec(VEC[i], i);

    // R9: stall the memory port, request must hold still
    @(negedge clk);
    stall     = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h4000_0010; req_strb = 4'hF;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(mem_valid && mem_addr == 32'h4000_0010 && !mem_write, "R9", "held under stall",
            mem_addr, 32'h4000_0010);
      @(negedge clk);
    end
    stall = 1'b0;
    for (int g = 0; g < 50 && !rsp_valid; g++) @(negedge clk);
    check(rsp_valid && rsp_rdata == 32'h0001_F00F, "R7", "read after stall",
          rsp_rdata, 32'h0001_F00F);

    // R5 under stall: aliased write to SRAM byte 0x301 bit 3, stall during write-back
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h2200_602C; req_wdata = 32'h1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 50 && !(mem_valid && mem_write); g++) @(negedge clk);
    stall = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_lock && mem_valid && mem_write && mem_strb == 4'b0010, "R5", "lock held while stalled",
          {27'h0, mem_lock, mem_strb}, 32'h12);
    stall = 1'b0;
    for (int g = 0; g < 50 && !rsp_valid; g++) @(negedge clk);
    @(negedge clk);
    check(!mem_lock, "R5", "lock released", 32'(mem_lock), 32'h0);
    run_vec('{1'b0, 32'h2000_0300, 32'h0, 4'hF, 32'h25FF_ADA3}, 17);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    finish_run();
  end

endmodule